// File: doc/BRIEF.md
# Parallel Flash Access Controller

This block connects a 32-bit register port to an external byte-wide parallel flash. Software programs a flash address and a direction bit in one command/status word. It then sets a launch bit and polls that bit until the hardware clears it. A second word carries the byte to write, or returns the byte read by the last completed read access.

When reset is released, the block first reads flash locations 0 and 1 on its own. It compares the two bytes with a 16-bit signature parameter and publishes the outcome as two read-only status flags. Register accesses are served during this sequence, but no software access can be launched until it ends. Every flash cycle has a fixed length. Chip enable and the active strobe stay low for the whole cycle, and the data bus is driven only for writes.

Top module: `flash_xfer_ctrl`

## Requirements
- R1: Word 0 (reg_addr_i=0) reads as {4'b0, init_done[27], init_ok[26], start[25], dir[24], 5'b0, addr[18:0]}. Bits 31:28 and 23:19 always read as zero. A write updates addr and dir, and the addr field drives fl_addr_o for the access it launches.
- R2: dir=1 makes the launched access a flash read. dir=0 makes it a flash write of the data byte.
- R3: Writing word 0 with bit 25 set launches an access. Bit 25 reads 1 for exactly ACC_CYCLES cycles after that write and is then cleared by the hardware.
- R4: After reset is released, an automatic read of flash addresses 0 and 1 runs. Bit 27 is 0 while it runs, then becomes 1 and stays 1 until the next reset.
- R5: Bit 26 becomes 1 only if the byte at address 0 equals INIT_SIG[15:8] and the byte at address 1 equals INIT_SIG[7:0]. Otherwise it stays 0.
- R6: Each access keeps fl_ce_no and exactly one strobe low for ACC_CYCLES consecutive cycles. fl_oe_no and fl_we_no are never low together. fl_data_oe_o is high only during write accesses.
- R7: Word 1 (reg_addr_i=1) holds the data byte in bits 7:0 and reads zero in bits 31:8. A write access drives this byte. A completed read access loads it with the flash byte.
- R8: A write with bit 25 set is ignored while an access is running or before bit 27 is set. Bits 27 and 26 cannot be changed by software writes.
- R9: In reset, all writable fields are zero and fl_ce_no, fl_oe_no and fl_we_no are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 1 | Word select: 0 command/status, 1 data |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read enable; read data is zero when low |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| fl_addr_o | output | 19 | Flash address |
| fl_data_i | input | 8 | Flash data bus, input side |
| fl_data_o | output | 8 | Flash data bus, output side |
| fl_data_oe_o | output | 1 | Flash data bus output enable |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |

## Verification
The assertions check the pin rules on every cycle: the strobes are exclusive, the bus is driven only under a write strobe, and every chip-enable pulse is exactly ACC_CYCLES long. They also check that the init flags are sticky and ordered, that the launch bit stays clear during initialization, and that it clears together with the end of a flash cycle. Only the bench scenarios can show the data values. These are the bytes landing at the right flash addresses across a sweep, read data returning to the data word, the signature match and mismatch outcomes, the exact poll length, and that launch requests are dropped while busy or initializing.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned BIT_IDONE = 27;
  localparam int unsigned BIT_IOK   = 26;
  localparam int unsigned BIT_START = 25;
  localparam int unsigned BIT_DIR   = 24;

  typedef enum logic [2:0] {
    INIT_RD0, INIT_WT0, INIT_RD1, INIT_WT1, INIT_FIN
  } init_state_e;
endpackage

// File: rtl/flash_access_engine.sv
module flash_access_engine #(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ACC_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cur_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic [DATA_W-1:0] fl_data_i,
  output logic [DATA_W-1:0] fl_data_o,
  output logic              fl_data_oe_o,
  output logic              fl_ce_no,
  output logic              fl_oe_no,
  output logic              fl_we_no
);
  localparam int unsigned CW = $clog2(ACC_CYCLES + 1);

  logic              busy_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (go_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      cnt_q  <= CW'(ACC_CYCLES - 1);
      addr_q <= addr_i;
      wd_q   <= wdata_i;
    end else if (busy_q && cnt_q == '0) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = busy_q && (cnt_q == '0);
  assign cur_rd_o     = rd_q;
  assign rdata_o      = fl_data_i;  // valid with done_o
  assign fl_addr_o    = addr_q;
  assign fl_data_o    = wd_q;
  assign fl_data_oe_o = busy_q && !rd_q;
  assign fl_ce_no     = !busy_q;
  assign fl_oe_no     = !(busy_q && rd_q);
  assign fl_we_no     = !(busy_q && !rd_q);
endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 19,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [2*DATA_W-1:0] INIT_SIG = 16'hA55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic              init_done_o,
  output logic              init_ok_o
);
  init_state_e       state_q;
  logic [DATA_W-1:0] b0_q;
  logic              ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INIT_RD0;
      b0_q    <= '0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        INIT_RD0: state_q <= INIT_WT0;
        INIT_WT0: if (done_i) begin
          b0_q    <= rdata_i;
          state_q <= INIT_RD1;
        end
        INIT_RD1: state_q <= INIT_WT1;
        INIT_WT1: if (done_i) begin
          ok_q    <= ({b0_q, rdata_i} == INIT_SIG);
          state_q <= INIT_FIN;
        end
        default:  state_q <= INIT_FIN;
      endcase
    end
  end

  assign go_o        = (state_q == INIT_RD0) || (state_q == INIT_RD1);
  assign addr_o      = (state_q == INIT_RD1 || state_q == INIT_WT1) ? ADDR_W'(1) : '0;
  assign active_o    = (state_q != INIT_FIN);
  assign init_done_o = (state_q == INIT_FIN);
  assign init_ok_o   = ok_q;
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              init_done_i,
  input  logic              init_ok_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              cur_rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              go_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              start_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q, start_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_wr, data_wr;

  assign cmd_wr  = reg_we_i && !reg_addr_i;
  assign data_wr = reg_we_i &&  reg_addr_i;
  assign go_o    = cmd_wr && reg_wdata_i[BIT_START] && init_done_i && !busy_i;
  assign rd_o    = reg_wdata_i[BIT_DIR];
  assign addr_o  = reg_wdata_i[ADDR_W-1:0];
  assign wdata_o = data_q;
  assign start_o = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (cmd_wr) begin
        addr_q <= reg_wdata_i[ADDR_W-1:0];
        dir_q  <= reg_wdata_i[BIT_DIR];
      end
      if (go_o)                  start_q <= 1'b1;
      else if (done_i && start_q) start_q <= 1'b0;
      // completed read wins over a same-cycle data write
      if (done_i && start_q && cur_rd_i) data_q <= rdata_i;
      else if (data_wr)                  data_q <= reg_wdata_i[DATA_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      if (reg_addr_i) begin
        reg_rdata_o[DATA_W-1:0] = data_q;
      end else begin
        reg_rdata_o[ADDR_W-1:0] = addr_q;
        reg_rdata_o[BIT_DIR]    = dir_q;
        reg_rdata_o[BIT_START]  = start_q;
        reg_rdata_o[BIT_IOK]    = init_ok_i;
        reg_rdata_o[BIT_IDONE]  = init_done_i;
      end
    end
  end
endmodule

// File: rtl/flash_xfer_ctrl.sv
module flash_xfer_ctrl #(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ACC_CYCLES = 4,
  parameter logic [15:0] INIT_SIG   = 16'hA55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [31:0]       reg_rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic [DATA_W-1:0] fl_data_i,
  output logic [DATA_W-1:0] fl_data_o,
  output logic              fl_data_oe_o,
  output logic              fl_ce_no,
  output logic              fl_oe_no,
  output logic              fl_we_no
);
  logic              busy, done, cur_rd;
  logic [DATA_W-1:0] rdata;
  logic              init_go, init_active, init_done, init_ok;
  logic [ADDR_W-1:0] init_addr;
  logic              sw_go, sw_rd, sw_start;
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic              eng_go, eng_rd;
  logic [ADDR_W-1:0] eng_addr;

  assign eng_go   = init_go || sw_go;
  assign eng_rd   = init_active ? 1'b1 : sw_rd;
  assign eng_addr = init_active ? init_addr : sw_addr;

  flash_access_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYCLES(ACC_CYCLES)
  ) u_engine (
    .clk_i, .rst_ni,
    .go_i(eng_go), .rd_i(eng_rd), .addr_i(eng_addr), .wdata_i(sw_wdata),
    .busy_o(busy), .done_o(done), .cur_rd_o(cur_rd), .rdata_o(rdata),
    .fl_addr_o, .fl_data_i, .fl_data_o, .fl_data_oe_o,
    .fl_ce_no, .fl_oe_no, .fl_we_no
  );

  flash_init_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SIG(INIT_SIG)
  ) u_init (
    .clk_i, .rst_ni, .done_i(done), .rdata_i(rdata),
    .go_o(init_go), .addr_o(init_addr), .active_o(init_active),
    .init_done_o(init_done), .init_ok_o(init_ok)
  );

  flash_cmd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wdata_i, .reg_we_i, .reg_re_i, .reg_rdata_o,
    .init_done_i(init_done), .init_ok_i(init_ok), .busy_i(busy), .done_i(done),
    .cur_rd_i(cur_rd), .rdata_i(rdata),
    .go_o(sw_go), .rd_o(sw_rd), .addr_o(sw_addr), .wdata_o(sw_wdata), .start_o(sw_start)
  );
endmodule

// File: rtl/flash_xfer_ctrl_chk.sv
module flash_xfer_ctrl_chk #(
  parameter int unsigned ACC_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fl_ce_no,
  input logic fl_oe_no,
  input logic fl_we_no,
  input logic fl_data_oe_o,
  input logic init_done,
  input logic init_ok,
  input logic sw_start
);
  logic [15:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_run <= '0;
    else if (fl_ce_no) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_oe_no && !fl_we_no)); // R6
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_data_oe_o |-> (!fl_we_no && !fl_ce_no)); // R6
  AST_CE_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_ce_no) |-> (low_run == 16'(ACC_CYCLES))); // R6
  AST_INIT_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done |=> init_done); // R4
  AST_INIT_OK_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_ok |-> init_done); // R5
  AST_NO_START_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done |-> !sw_start); // R8
  AST_START_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_start) |-> $rose(fl_ce_no)); // R3
endmodule

bind flash_xfer_ctrl flash_xfer_ctrl_chk #(.ACC_CYCLES(ACC_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fl_ce_no(fl_ce_no), .fl_oe_no(fl_oe_no),
  .fl_we_no(fl_we_no), .fl_data_oe_o(fl_data_oe_o), .init_done(init_done),
  .init_ok(init_ok), .sw_start(sw_start)
);

// File: tb/flash_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module flash_xfer_ctrl_bench;
  localparam int ACC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [18:0] fl_addr;
  logic [7:0]  fl_din, fl_dout;
  logic        fl_doe, fl_ce_n, fl_oe_n, fl_we_n;

  int tests = 0, fails = 0, cyc = 0;
  int acc_count = 0;
  int pin_err = 0;
  logic [18:0] last_addr = '0;

  logic [7:0] mem [256];
  logic       pre_en = 1'b0;
  logic [7:0] pre_a = '0, pre_d = '0;

  always #2.5 clk = ~clk;

  flash_xfer_ctrl u_flash_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_rdata_o(reg_rdata),
    .fl_addr_o(fl_addr), .fl_data_i(fl_din), .fl_data_o(fl_dout),
    .fl_data_oe_o(fl_doe), .fl_ce_no(fl_ce_n), .fl_oe_no(fl_oe_n), .fl_we_no(fl_we_n)
  );

  assign fl_din = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[7:0]] : 8'h00;

  logic ce_n_d = 1'b1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    ce_n_d <= fl_ce_n;
    if (pre_en) mem[pre_a] <= pre_d;
    else if (!fl_ce_n && !fl_we_n) mem[fl_addr[7:0]] <= fl_dout;
    if (ce_n_d && !fl_ce_n) begin
      acc_count <= acc_count + 1;
      last_addr <= fl_addr;
    end
    if (!fl_oe_n && !fl_we_n) pin_err <= pin_err + 1;
    if (fl_doe && fl_we_n)    pin_err <= pin_err + 1;
    if (!fl_ce_n && fl_oe_n && fl_we_n) pin_err <= pin_err + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pre_en = 1'b1; pre_a = a; pre_d = d;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic reg_wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [31:0] d);
    reg_addr = a; reg_re = 1'b1; #0.5; d = reg_rdata; reg_re = 1'b0;
  endtask

  // launch an access and return how many cycles bit 25 read 1
  task automatic sw_access(input logic [18:0] a, input logic rd, output int n);
    logic [31:0] v;
    reg_wr(1'b0, (32'h1 << 25) | (32'(rd) << 24) | 32'(a));
    n = 0;
    reg_rd(1'b0, v);
    while (v[25] && n < 50) begin
      @(negedge clk); n++;
      reg_rd(1'b0, v);
    end
  endtask

  task automatic wait_init();
    logic [31:0] v;
    int k = 0;
    reg_rd(1'b0, v);
    while (!v[27] && k < 100) begin
      @(negedge clk); k++; reg_rd(1'b0, v);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial begin
    logic [31:0] v;
    int n, acc0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pre_en = 1'b1; pre_a = 8'(i); pre_d = 8'hEE;
    end
    @(negedge clk); pre_en = 1'b0;
    preload(8'd0, 8'hA5);
    preload(8'd1, 8'h5A);

    // R9: reset values
    reg_rd(1'b0, v); check("R9 cmd word in reset", v, 32'h0);
    reg_rd(1'b1, v); check("R9 data word in reset", v, 32'h0);
    check("R9 pins idle in reset", {29'b0, fl_ce_n, fl_oe_n, fl_we_n}, 32'h7);

    @(negedge clk); rst_n = 1'b1;
    reg_rd(1'b0, v); check("R4 init busy after release", 32'(v[27]), 32'h0);
    // R8: launch during init must be dropped
    reg_wr(1'b1, 32'h0000_0033);
    reg_wr(1'b0, (32'h1 << 25) | 32'd200);
    reg_rd(1'b0, v); check("R8 start ignored in init", 32'(v[25]), 32'h0);
    wait_init();
    reg_rd(1'b0, v); check("R4 init done", 32'(v[27]), 32'h1);
    check("R5 signature match", 32'(v[26]), 32'h1);
    check("R4 two init reads", 32'(acc_count), 32'd2);
    check("R8 no write at addr 200", 32'(mem[200]), 32'hEE);

    // R1: field layout, reserved zero, status not writable
    reg_wr(1'b0, 32'hFC00_0005);
    reg_rd(1'b0, v); check("R1 R8 reserved and status", v, 32'h0C00_0005);
    reg_wr(1'b0, 32'h0087_0003);
    reg_rd(1'b0, v); check("R1 reserved 23:19 zero", v, 32'h0C07_0003);
    reg_wr(1'b0, 32'h0100_0003);
    reg_rd(1'b0, v); check("R1 dir field", v, 32'h0D00_0003);
    reg_wr(1'b1, 32'hFFFF_FFFF);
    reg_rd(1'b1, v); check("R7 data word upper zero", v, 32'h0000_00FF);

    // write sweep (R2 write, R3 timing, R7 source)
    for (int a = 16; a < 80; a++) begin
      reg_wr(1'b1, 32'(pat(a)));
      sw_access(19'(a), 1'b0, n);
      check("R3 start clear time", 32'(n), 32'(ACC));
      check("R2 R7 byte written", 32'(mem[a]), 32'(pat(a)));
    end
    // read sweep (R2 read, R7 return)
    reg_wr(1'b1, 32'h0);
    for (int a = 16; a < 80; a++) begin
      sw_access(19'(a), 1'b1, n);
      reg_rd(1'b1, v); check("R2 R7 byte read", v, 32'(pat(a)));
      check("R2 read leaves flash", 32'(mem[a]), 32'(pat(a)));
    end

    // R1: address to pins
    sw_access(19'h7FF10, 1'b1, n);
    check("R1 address on pins", 32'(last_addr), 32'h7FF10);

    // R8: second launch during an access
    acc0 = acc_count;
    reg_wr(1'b1, 32'h0000_0077);
    reg_wr(1'b0, (32'h1 << 25) | 32'd100);
    reg_wr(1'b0, (32'h1 << 25) | 32'd101);
    repeat (ACC + 2) @(negedge clk);
    check("R8 one access only", 32'(acc_count - acc0), 32'd1);
    check("R8 first write landed", 32'(mem[100]), 32'h77);
    check("R8 second write dropped", 32'(mem[101]), 32'hEE);
    reg_rd(1'b0, v); check("R3 start cleared", 32'(v[25]), 32'h0);

    // R5: bad signature after new reset
    preload(8'd1, 8'h5B);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    reg_rd(1'b0, v); check("R9 cmd cleared by reset", v, 32'h0);
    reg_rd(1'b1, v); check("R9 data cleared by reset", v, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    wait_init();
    reg_rd(1'b0, v); check("R4 init done again", 32'(v[27]), 32'h1);
    check("R5 signature mismatch", 32'(v[26]), 32'h0);

    check("R6 pin rules", 32'(pin_err), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule